// File: doc/BRIEF.md
# Reserved and hint instruction classifier

This block watches a stream of 32-bit base-integer instruction words, one per cycle, and sorts each qualified word into exactly one category: an ordinary instruction, a hint in the space kept for standard use, a hint in the space left to custom use, a reserved encoding, or one of five named hints. The named hints are four non-temporal locality hints and a spin-wait pause. A front-end or decoder uses the result to turn hints into no-ops or to attach side effects to them, and to trap or log reserved encodings. The block does no operand decode and does no execution. It inspects only the opcode, the function fields, the register fields and a few immediate bits.

The result appears one clock after the word is presented. It takes the form of five registered one-hot category flags and a 3-bit code that identifies a named hint.

Top module: `hint_classifier`

## Requirements
- R1: The outputs are registered. A word presented with `valid_i` high is classified on `valid_o` and the flags one cycle later. A cycle with `valid_i` low gives `valid_o`, every flag and `hint_code_o` all zero on the next cycle. Reset clears every output.
- R2: When `valid_o` is high, exactly one of `normal_o`, `std_hint_o`, `cust_hint_o`, `rsvd_o` and `named_o` is set. Any encoding not covered by R3 to R9 is reported as normal. This includes unknown opcodes, unknown funct7 values and destinations other than x0. Field positions: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25].
- R3: On opcode 0011011, a shift word is reserved for any rd when it has funct3 001 with [31:26]=000000, or funct3 101 with [31:26] equal to 000000 or 010000, and bit 25 is set.
- R4: With rd=x0, the following are standard hints: opcodes 0110111 and 0010111; opcode 0010011 with funct3 100, 110 or 111; opcode 0011011 with funct3 000; opcode 0110011 with funct7 0000000 and funct3 000, 001, 100, 101, 110 or 111, or with funct7 0100000 and funct3 000 or 101; opcode 0111011 with funct7 0000000 and funct3 000, 001 or 101, or with funct7 0100000 and funct3 000 or 101.
- R5: Opcode 0010011 with funct3 000 and rd=x0 is a standard hint when rs1 is nonzero or imm [31:20] is nonzero. The all-zero word 0x00000013 is normal.
- R6: Opcode 0110011 with funct7 0000000, funct3 000, rd=x0 and rs1=x0 is a named hint when rs2 is x2, x3, x4 or x5, with `hint_code_o` equal to 1, 2, 3 or 4 in that order. Any other rs2 gives a standard hint.
- R7: Opcode 0001111 with funct3 000, rd=rs1=x0, fm [31:28]=0, predecessor [27:24]=0001 and successor [23:20]=0000 is the named pause hint, with `hint_code_o`=5.
- R8: With rd=x0, the following are custom hints: opcode 0010011 with funct3 010 or 011; opcode 0110011 with funct7 0000000 and funct3 010 or 011; opcode 0010011 with funct3 001 and [31:26]=000000, or with funct3 101 and [31:26] equal to 000000 or 010000; opcode 0011011 shift words whose bit 25 is clear.
- R9: Opcode 0001111 with funct3 000, fm=0 and an empty predecessor or successor set is a standard hint when at least one of rd and rs1 is x0 and the word is not the R7 pause. When both rd and rs1 are nonzero the word is normal.
- R10: `hint_code_o` is nonzero only while `named_o` is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Qualifies `insn_i` this cycle |
| insn_i | input | 32 | Instruction word to classify |
| valid_o | output | 1 | Classification result is present |
| normal_o | output | 1 | Ordinary instruction |
| std_hint_o | output | 1 | Hint in the standard space (unnamed) |
| cust_hint_o | output | 1 | Hint in the custom space |
| rsvd_o | output | 1 | Reserved encoding |
| named_o | output | 1 | One of the named hints |
| hint_code_o | output | 3 | 0 none, 1 to 4 locality hints, 5 pause |

## Verification
Every cycle, the assertions check that the flags are one-hot under `valid_o` and silent without it. They also check that valid is delayed by one cycle, that the hint code agrees with the named flag, and that a reserved or custom flag traces back to the opcode and destination of the previous word. The split between standard and custom spaces, the edge cases around the ADDI no-op, the order of the locality hints, and the fence field combinations can only be shown by the bench. The bench sweeps opcodes, function fields, register values and fence sets against its own classification model.

// File: rtl/hint_classifier.sv
module hint_classifier (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  output logic        valid_o,
  output logic        normal_o,
  output logic        std_hint_o,
  output logic        cust_hint_o,
  output logic        rsvd_o,
  output logic        named_o,
  output logic [2:0]  hint_code_o
);
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMMW  = 7'b0011011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REGW  = 7'b0111011;
  localparam logic [6:0] OPC_FENCE = 7'b0001111;
  localparam logic [6:0] F7_ALT    = 7'b0100000;
  localparam logic [5:0] F6_ALT    = 6'b010000;

  wire [6:0] opc   = insn_i[6:0];
  wire [2:0] f3    = insn_i[14:12];
  wire [6:0] f7    = insn_i[31:25];
  wire [5:0] f6    = insn_i[31:26];
  wire [4:0] rs2   = insn_i[24:20];
  wire [3:0] fm    = insn_i[31:28];
  wire [3:0] pred  = insn_i[27:24];
  wire [3:0] succ  = insn_i[23:20];
  wire       rd0   = insn_i[11:7] == 5'd0;
  wire       rs10  = insn_i[19:15] == 5'd0;
  wire       imm0  = insn_i[31:20] == 12'd0;
  wire       sh_ok = (f3 == 3'b001 && f6 == 6'd0) ||
                     (f3 == 3'b101 && (f6 == 6'd0 || f6 == F6_ALT));
  wire       alt_ok = f3 == 3'b000 || f3 == 3'b101;

  logic       c_std, c_cus, c_rsv;
  logic [2:0] c_code;

  always_comb begin
    c_std  = 1'b0;
    c_cus  = 1'b0;
    c_rsv  = 1'b0;
    c_code = 3'd0;
    unique case (opc)
      OPC_LUI, OPC_AUIPC: c_std = rd0;
      OPC_IMM: begin
        if (f3 == 3'b000)                         c_std = rd0 && (!rs10 || !imm0);
        else if (f3 == 3'b010 || f3 == 3'b011)    c_cus = rd0;
        else if (f3 == 3'b001 || f3 == 3'b101)    c_cus = rd0 && sh_ok;
        else                                      c_std = rd0;
      end
      OPC_IMMW: begin
        if (f3 == 3'b000) c_std = rd0;
        else if (sh_ok) begin
          c_rsv = insn_i[25];
          c_cus = !insn_i[25] && rd0;
        end
      end
      OPC_REG: begin
        if (rd0 && (f7 == 7'd0 || (f7 == F7_ALT && alt_ok))) begin
          if (f3 == 3'b010 || f3 == 3'b011)
            c_cus = 1'b1;
          else if (f3 == 3'b000 && f7 == 7'd0 && rs10 && rs2 >= 5'd2 && rs2 <= 5'd5)
            c_code = 3'(rs2 - 5'd1);
          else
            c_std = 1'b1;
        end
      end
      OPC_REGW: begin
        c_std = rd0 && ((f7 == 7'd0 && (alt_ok || f3 == 3'b001)) ||
                        (f7 == F7_ALT && alt_ok));
      end
      OPC_FENCE: begin
        if (f3 == 3'b000 && fm == 4'd0 && (pred == 4'd0 || succ == 4'd0) && (rd0 || rs10)) begin
          if (rd0 && rs10 && pred == 4'b0001 && succ == 4'd0) c_code = 3'd5;
          else                                                 c_std  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  wire c_named = c_code != 3'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      normal_o    <= 1'b0;
      std_hint_o  <= 1'b0;
      cust_hint_o <= 1'b0;
      rsvd_o      <= 1'b0;
      named_o     <= 1'b0;
      hint_code_o <= 3'd0;
    end else begin
      valid_o     <= valid_i;
      normal_o    <= valid_i && !(c_std || c_cus || c_rsv || c_named);
      std_hint_o  <= valid_i && c_std;
      cust_hint_o <= valid_i && c_cus;
      rsvd_o      <= valid_i && c_rsv;
      named_o     <= valid_i && c_named;
      hint_code_o <= valid_i ? c_code : 3'd0;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ({normal_o, std_hint_o, cust_hint_o, rsvd_o, named_o} == 5'd0 && hint_code_o == 3'd0));
  // R2
  one_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({normal_o, std_hint_o, cust_hint_o, rsvd_o, named_o}) == 1);
  // R3
  rsvd_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> ($past(insn_i[6:0]) == OPC_IMMW && $past(insn_i[25])));
  // R8
  cust_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cust_hint_o |-> $past(insn_i[11:7]) == 5'd0);
  // R7
  pause_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_code_o == 3'd5 |-> $past(insn_i[6:0]) == OPC_FENCE);
  // R10
  code_named_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hint_code_o != 3'd0) == named_o);
  // R10
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_code_o <= 3'd5);
endmodule

// File: tb/tb_hint_classifier.sv
module tb_hint_classifier;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = 32'd0;
  logic        valid_o, normal_o, std_hint_o, cust_hint_o, rsvd_o, named_o;
  logic [2:0]  hint_code_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .valid_o(valid_o), .normal_o(normal_o), .std_hint_o(std_hint_o),
    .cust_hint_o(cust_hint_o), .rsvd_o(rsvd_o), .named_o(named_o),
    .hint_code_o(hint_code_o)
  );

  // expected {valid, normal, std, cust, rsvd, named, code[2:0]}
  function automatic logic [8:0] model(input logic [31:0] w);
    logic [4:0] rd, rs1, rs2;
    logic [2:0] f3;
    logic [6:0] f7, op;
    bit is_std, is_cus, is_rsv, shift_form;
    int code;
    op = w[6:0]; rd = w[11:7]; f3 = w[14:12]; rs1 = w[19:15];
    rs2 = w[24:20]; f7 = w[31:25];
    is_std = 0; is_cus = 0; is_rsv = 0; code = 0;
    shift_form = (f3 == 1 && w[31:26] == 0) || (f3 == 5 && (w[31:26] == 0 || w[31:26] == 6'h10));
    // R3 reserved word shifts
    if (op == 7'h1B && f3 != 0 && shift_form && w[25]) is_rsv = 1;
    else if (op == 7'h0F && f3 == 0) begin
      // R7, R9
      if (w[31:28] == 0 && (w[27:24] == 0 || w[23:20] == 0) && (rd == 0 || rs1 == 0)) begin
        if (rd == 0 && rs1 == 0 && w[27:24] == 1 && w[23:20] == 0) code = 5;
        else is_std = 1;
      end
    end else if (rd == 0) begin
      case (op)
        7'h37, 7'h17: is_std = 1;                             // R4
        7'h13: begin
          if (f3 == 0) is_std = (rs1 != 0) || (w[31:20] != 0); // R5
          else if (f3 == 2 || f3 == 3) is_cus = 1;           // R8
          else if (f3 == 1 || f3 == 5) is_cus = shift_form;  // R8
          else is_std = 1;                                   // R4
        end
        7'h1B: begin
          if (f3 == 0) is_std = 1;
          else if (shift_form) is_cus = 1;                   // R8
        end
        7'h33: begin
          if (f7 == 0 && (f3 == 2 || f3 == 3)) is_cus = 1;
          else if (f7 == 0 && f3 == 0 && rs1 == 0 && rs2 >= 2 && rs2 <= 5) code = rs2 - 1; // R6
          else if (f7 == 0 || (f7 == 7'h20 && (f3 == 0 || f3 == 5))) is_std = 1;
        end
        7'h3B: begin
          if ((f7 == 0 && (f3 == 0 || f3 == 1 || f3 == 5)) || (f7 == 7'h20 && (f3 == 0 || f3 == 5)))
            is_std = 1;
        end
        default: ;
      endcase
    end
    return {1'b1, !(is_std || is_cus || is_rsv || code != 0), is_std, is_cus, is_rsv, code != 0, 3'(code)};
  endfunction

  function automatic string tag_of(input logic [8:0] e);
    if (e[4]) return "R3";
    if (e[2:0] == 5) return "R7";
    if (e[3]) return "R6";
    if (e[5]) return "R8";
    if (e[6]) return "R4/R5/R9";
    return "R2";
  endfunction

  task automatic check(input logic [8:0] exp, input string tag, input logic [31:0] w);
    logic [8:0] act;
    act = {valid_o, normal_o, std_hint_o, cust_hint_o, rsvd_o, named_o, hint_code_o};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s word=%h actual=%b expected=%b", tag, w, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    logic [8:0] e;
    @(negedge clk);
    valid_i = 1'b1;
    insn_i = w;
    @(posedge clk);
    #1;
    e = model(w);
    check(e, tag_of(e), w);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [6:0] ops [9];
    logic [6:0] f7s [4];
    ops = '{7'h37, 7'h17, 7'h13, 7'h1B, 7'h33, 7'h3B, 7'h0F, 7'h03, 7'h63};
    f7s = '{7'h00, 7'h01, 7'h20, 7'h21};
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(9'd0, "R1", 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 locality hints in order, R7 pause, R5 no-op
    for (int r = 0; r < 8; r++) apply({7'd0, 5'(r), 5'd0, 3'd0, 5'd0, 7'h33});
    apply(32'h0100000F);
    apply(32'h00000013);
    apply(32'h00100013);
    apply(32'h00008013);
    // R3 reserved regardless of rd
    apply({7'h01, 5'd3, 5'd4, 3'd1, 5'd9, 7'h1B});
    apply({7'h21, 5'd3, 5'd4, 3'd5, 5'd0, 7'h1B});

    // R2/R4/R8 sweep
    foreach (ops[i]) begin
      for (int f3 = 0; f3 < 8; f3++)
        foreach (f7s[k])
          for (int rd = 0; rd < 2; rd++)
            for (int rs1 = 0; rs1 < 2; rs1++)
              for (int rs2 = 0; rs2 < 7; rs2++)
                apply({f7s[k], 5'(rs2), (rs1 != 0) ? 5'd9 : 5'd0, 3'(f3), 5'(rd), ops[i]});
    end

    // R7/R9 fence sweep
    for (int fmv = 0; fmv < 3; fmv++)
      for (int p = 0; p < 16; p++)
        for (int s = 0; s < 16; s++)
          for (int rd = 0; rd < 2; rd++)
            for (int rs1 = 0; rs1 < 2; rs1++)
              apply({(fmv == 0) ? 4'd0 : (fmv == 1 ? 4'd1 : 4'd8), 4'(p), 4'(s),
                     (rs1 != 0) ? 5'd2 : 5'd0, 3'd0, (rd != 0) ? 5'd2 : 5'd0, 7'h0F});

    // R5 immediate sweep for rd=x0, rs1=x0
    for (int im = 0; im < 4096; im += 97) apply({12'(im), 5'd0, 3'd0, 5'd0, 7'h13});

    // R1 valid low: hint word presented, outputs stay quiet
    @(negedge clk);
    valid_i = 1'b0;
    insn_i = 32'h0100000F;
    @(posedge clk);
    #1;
    check(9'd0, "R1", insn_i);
    @(posedge clk);
    #1;
    check(9'd0, "R1", insn_i);

    // R10 pseudo-random words
    for (int n = 0; n < 3000; n++) apply($urandom);

    finish_run();
  end
endmodule